// File: doc/BRIEF.md
# Audio Unit Test Register Port

This block adds a small test-only register window to a multi-channel sound generator. While an external test-enable pin is high, the CPU can read the live amplitude of every channel through three byte-wide addresses that sit just above the normal audio registers. It can also write one control byte that forces the triangle channel's phase counter and silences every channel on its way to the mixer. While the pin is low, the three addresses act as unused space: reads leave the bus undriven and writes change nothing.

The block has no channel generators and no mixer. It takes the current channel amplitudes as inputs and returns them, with gating applied, as the mixer feeds. It also sends a one-cycle phase-load strobe and a 5-bit phase value to the triangle generator. Read data is combinational, so it is valid in the same cycle as the read request. The mute state is held in a register and takes effect on the clock edge that accepts the write.

Top module: `aut_test_port`

## Requirements
- R1: After reset the mute latch is 0, `bus_rdata_oe` is 0, `tri_phase_ld` is 0 and `bus_rdata` is 0.
- R2: A read with test mode on at offset 0x18 drives `bus_rdata_oe`=1 and `bus_rdata` = {pulse 1 amplitude, pulse 0 amplitude}, with pulse 0 on bits 3:0, in the same cycle.
- R3: A read with test mode on at offset 0x19 returns the triangle amplitude on bits 3:0 and the noise amplitude on bits 7:4, in the same cycle.
- R4: A read with test mode on at offset 0x1A returns the 7-bit sample DAC value on bits 6:0, with bit 7 always 0.
- R5: A write with test mode on at offset 0x1A raises `tri_phase_ld` for exactly that cycle, with `tri_phase_val` equal to write data bits 4:0.
- R6: Write data bit 7 at offset 0x1A loads the mute latch at that clock edge: 1 mutes and 0 unmutes. Without such a write the latch holds its value.
- R7: While the latch is set, all five mixer feeds read 0. The read port still shows the live channel amplitudes.
- R8: With test mode off, reads of 0x18 to 0x1A give `bus_rdata_oe`=0 and `bus_rdata`=0. Writes give no strobe and leave the mute latch unchanged.
- R9: Addresses outside 0x18 to 0x1A never drive the bus and never act as the control write, even with test mode on.
- R10: While the latch is clear, each mixer feed equals its channel input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| test_en | input | 1 | Test pin; qualifies every test access |
| bus_addr | input | 5 | Register offset |
| bus_rd | input | 1 | Read request |
| bus_wr | input | 1 | Write request |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when not driven |
| bus_rdata_oe | output | 1 | Read data output enable |
| pulse0_amp | input | 4 | Pulse 0 live amplitude |
| pulse1_amp | input | 4 | Pulse 1 live amplitude |
| tri_amp | input | 4 | Triangle live amplitude |
| noise_amp | input | 4 | Noise live amplitude |
| dac_val | input | 7 | Sample DAC value |
| mix_pulse0 | output | 4 | Gated pulse 0 to the mixer |
| mix_pulse1 | output | 4 | Gated pulse 1 to the mixer |
| mix_tri | output | 4 | Gated triangle to the mixer |
| mix_noise | output | 4 | Gated noise to the mixer |
| mix_dac | output | 7 | Gated DAC value to the mixer |
| tri_phase_ld | output | 1 | One-cycle triangle phase load strobe |
| tri_phase_val | output | 5 | Phase position to load |
| mute_active | output | 1 | Mute latch state |

## Verification
A single control byte can force the triangle phase and set the mute in the same write. The bench writes 0x80 combined with a phase value. It checks that the strobe and phase value appear in that cycle, while the mixer feeds still carry live values. It then checks that every feed reads 0 starting from the next cycle. It also drops the test pin during a write that would set mute, and judges the result by the absence of the strobe and by the mixer feeds staying live.

// File: rtl/aut_pkg.sv
package aut_pkg;

  typedef enum logic [1:0] {
    PORT_NONE   = 2'd0,
    PORT_PULSE  = 2'd1,
    PORT_TRINOI = 2'd2,
    PORT_DAC    = 2'd3
  } port_e;

  // two amplitudes side by side, first one in the low half
  function automatic logic [7:0] pack_pair(input logic [3:0] lo, input logic [3:0] hi);
    return {hi, lo};
  endfunction

  // DAC value widened to a byte, top bit forced low
  function automatic logic [7:0] pad_dac(input logic [6:0] v);
    return {1'b0, v};
  endfunction

endpackage

// File: rtl/aut_decode.sv
module aut_decode
  import aut_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int BASE_OFS = 'h18
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic              test_en,
  output port_e             sel,
  output logic              rd_ok,
  output logic              wr_ok
);
  localparam logic [ADDR_W-1:0] OFS0 = ADDR_W'(BASE_OFS);

  logic [ADDR_W-1:0] rel;
  assign rel = addr - OFS0;

  always_comb begin
    sel = PORT_NONE;
    if (addr >= OFS0) begin
      if (rel == ADDR_W'(0))      sel = PORT_PULSE;
      else if (rel == ADDR_W'(1)) sel = PORT_TRINOI;
      else if (rel == ADDR_W'(2)) sel = PORT_DAC;
    end
  end

  assign rd_ok = rd && test_en && (sel != PORT_NONE);
  assign wr_ok = wr && test_en && (sel == PORT_DAC);
endmodule

// File: rtl/aut_ctrl.sv
module aut_ctrl #(
  parameter int PHASE_W = 5,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ok,
  input  logic [DATA_W-1:0]  wdata,
  output logic               mute_q,
  output logic               phase_ld,
  output logic [PHASE_W-1:0] phase_val
);
  localparam int MUTE_BIT = DATA_W - 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mute_q <= 1'b0;
    else if (wr_ok) mute_q <= wdata[MUTE_BIT];
  end

  assign phase_ld  = wr_ok;
  assign phase_val = wdata[PHASE_W-1:0];

  AST_MUTE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && wdata[MUTE_BIT]) |=> mute_q); // R6
  AST_MUTE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !wdata[MUTE_BIT]) |=> !mute_q); // R6
  AST_MUTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ok |=> $stable(mute_q)); // R6
endmodule

// File: rtl/aut_gate.sv
module aut_gate #(
  parameter int W = 4
) (
  input  logic         mute,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  assign dout = din & {W{~mute}};
endmodule

// File: rtl/aut_test_port.sv
module aut_test_port
  import aut_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int BASE_OFS = 'h18,
  parameter int AMP_W    = 4,
  parameter int DAC_W    = 7,
  parameter int PHASE_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               test_en,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [2*AMP_W-1:0] bus_wdata,
  output logic [2*AMP_W-1:0] bus_rdata,
  output logic               bus_rdata_oe,
  input  logic [AMP_W-1:0]   pulse0_amp,
  input  logic [AMP_W-1:0]   pulse1_amp,
  input  logic [AMP_W-1:0]   tri_amp,
  input  logic [AMP_W-1:0]   noise_amp,
  input  logic [DAC_W-1:0]   dac_val,
  output logic [AMP_W-1:0]   mix_pulse0,
  output logic [AMP_W-1:0]   mix_pulse1,
  output logic [AMP_W-1:0]   mix_tri,
  output logic [AMP_W-1:0]   mix_noise,
  output logic [DAC_W-1:0]   mix_dac,
  output logic               tri_phase_ld,
  output logic [PHASE_W-1:0] tri_phase_val,
  output logic               mute_active
);
  localparam int DATA_W = 2 * AMP_W;
  localparam int N_AMP  = 4;
  localparam logic [ADDR_W-1:0] DAC_OFS = ADDR_W'(BASE_OFS + 2);

  port_e sel;
  logic  rd_ok, wr_ok, mute_q;
  logic [DATA_W-1:0] rd_mux;

  aut_decode #(.ADDR_W(ADDR_W), .BASE_OFS(BASE_OFS)) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .test_en(test_en),
    .sel(sel), .rd_ok(rd_ok), .wr_ok(wr_ok)
  );

  aut_ctrl #(.PHASE_W(PHASE_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wdata(bus_wdata),
    .mute_q(mute_q), .phase_ld(tri_phase_ld), .phase_val(tri_phase_val)
  );

  always_comb begin
    unique case (sel)
      PORT_PULSE:  rd_mux = pack_pair(pulse0_amp, pulse1_amp);
      PORT_TRINOI: rd_mux = pack_pair(tri_amp, noise_amp);
      PORT_DAC:    rd_mux = pad_dac(dac_val);
      default:     rd_mux = '0;
    endcase
  end

  assign bus_rdata_oe = rd_ok;
  assign bus_rdata    = rd_ok ? rd_mux : '0;
  assign mute_active  = mute_q;

  logic [AMP_W-1:0] amp_in  [N_AMP];
  logic [AMP_W-1:0] amp_out [N_AMP];
  assign amp_in[0] = pulse0_amp;
  assign amp_in[1] = pulse1_amp;
  assign amp_in[2] = tri_amp;
  assign amp_in[3] = noise_amp;

  for (genvar g = 0; g < N_AMP; g++) begin : g_amp_gate
    aut_gate #(.W(AMP_W)) u_gate (.mute(mute_q), .din(amp_in[g]), .dout(amp_out[g]));
  end

  aut_gate #(.W(DAC_W)) u_dac_gate (.mute(mute_q), .din(dac_val), .dout(mix_dac));

  assign mix_pulse0 = amp_out[0];
  assign mix_pulse1 = amp_out[1];
  assign mix_tri    = amp_out[2];
  assign mix_noise  = amp_out[3];

  AST_OE_NEEDS_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata_oe |-> test_en); // R8
  AST_LD_NEEDS_WR: assert property (@(posedge clk) disable iff (!rst_n)
    tri_phase_ld |-> (test_en && bus_wr && bus_addr == DAC_OFS)); // R5
  AST_DAC_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata_oe && bus_addr == DAC_OFS) |-> !bus_rdata[DATA_W-1]); // R4
  AST_MUTE_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    mute_active |-> (mix_pulse0 == '0 && mix_pulse1 == '0 && mix_tri == '0
                     && mix_noise == '0 && mix_dac == '0)); // R7
  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rdata_oe |-> (bus_rdata == '0)); // R9
endmodule

// File: tb/aut_test_port_test.sv
module aut_test_port_test;
  logic clk = 1'b0, rst_n = 1'b0, test_en = 1'b0;
  logic [4:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic bus_rdata_oe;
  logic [3:0] pulse0_amp = '0, pulse1_amp = '0, tri_amp = '0, noise_amp = '0;
  logic [6:0] dac_val = '0;
  logic [3:0] mix_pulse0, mix_pulse1, mix_tri, mix_noise;
  logic [6:0] mix_dac;
  logic tri_phase_ld, mute_active;
  logic [4:0] tri_phase_val;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  aut_test_port uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_ch(input logic [3:0] p0, p1, tr, nz, input logic [6:0] d);
    pulse0_amp = p0; pulse1_amp = p1; tri_amp = tr; noise_amp = nz; dac_val = d;
  endtask

  // read in one cycle; returns {oe, data}
  task automatic rd(input logic [4:0] a, output logic [8:0] r);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1;
    r = {bus_rdata_oe, bus_rdata};
    @(negedge clk); bus_rd = 1'b0;
  endtask

  // write in one cycle; returns {ld, phase} seen in the write cycle
  task automatic wr(input logic [4:0] a, input logic [7:0] d, output logic [5:0] s);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1; #1;
    s = {tri_phase_ld, tri_phase_val};
    @(negedge clk); bus_wr = 1'b0; #1;
  endtask

  function automatic logic [25:0] mixv();
    return {mix_pulse0, mix_pulse1, mix_tri, mix_noise, mix_dac, mute_active};
  endfunction

  task automatic t_reset();
    #1;
    chk("R1 mute", mute_active, 0);
    chk("R1 oe", bus_rdata_oe, 0);
    chk("R1 ld", tri_phase_ld, 0);
    chk("R1 rdata", bus_rdata, 0);
  endtask

  task automatic t_reads();
    logic [8:0] r;
    test_en = 1'b1;
    set_ch(4'h3, 4'hC, 4'h9, 4'h5, 7'h41);
    rd(5'h18, r); chk("R2 pulse pair", r, 9'h1C3);
    set_ch(4'hF, 4'h0, 4'h9, 4'h5, 7'h41);
    rd(5'h18, r); chk("R2 pulse pair b", r, 9'h10F);
    rd(5'h19, r); chk("R3 tri/noise", r, 9'h159);
    set_ch(4'h0, 4'h0, 4'hE, 4'h1, 7'h7F);
    rd(5'h19, r); chk("R3 tri/noise b", r, 9'h11E);
    rd(5'h1A, r); chk("R4 dac max, bit7 0", r, 9'h17F);
    set_ch(4'h0, 4'h0, 4'h0, 4'h0, 7'h02);
    rd(5'h1A, r); chk("R4 dac small", r, 9'h102);
  endtask

  task automatic t_passthrough();
    set_ch(4'h1, 4'h2, 4'h3, 4'h4, 7'h55); #1;
    chk("R10 feeds live", mixv(), {4'h1, 4'h2, 4'h3, 4'h4, 7'h55, 1'b0});
  endtask

  task automatic t_phase_and_mute_same_write();
    logic [5:0] s;
    logic [8:0] r;
    test_en = 1'b1;
    set_ch(4'h6, 4'h7, 4'h8, 4'h9, 7'h33);
    @(negedge clk); bus_addr = 5'h1A; bus_wdata = 8'h95; bus_wr = 1'b1; #1;
    chk("R5 strobe in write cycle", {tri_phase_ld, tri_phase_val}, {1'b1, 5'h15});
    chk("R6 feeds live before edge", mixv(), {4'h6, 4'h7, 4'h8, 4'h9, 7'h33, 1'b0});
    @(negedge clk); bus_wr = 1'b0; #1;
    chk("R5 strobe single cycle", tri_phase_ld, 0);
    chk("R7 muted feeds", mixv(), {22'h0, 1'b1} | 26'h0);
    rd(5'h19, r); chk("R7 live read while muted", r, 9'h198);
    set_ch(4'hA, 4'hB, 4'hC, 4'hD, 7'h7E); #1;
    chk("R7 muted after change", mixv(), 26'h1);
    wr(5'h1A, 8'h1F, s);
    chk("R5 phase 1F, no mute bit", s, {1'b1, 5'h1F});
    chk("R6 clear mute", mixv(), {4'hA, 4'hB, 4'hC, 4'hD, 7'h7E, 1'b0});
  endtask

  task automatic t_test_off();
    logic [5:0] s;
    logic [8:0] r;
    test_en = 1'b0;
    for (int a = 5'h18; a <= 5'h1A; a++) begin
      rd(a[4:0], r); chk("R8 read with test off", r, 9'h000);
    end
    wr(5'h1A, 8'h80, s);
    chk("R8 no strobe with test off", s[5], 0);
    chk("R8 mute unchanged", mute_active, 0);
    chk("R8 feeds live", mix_tri, 4'hC);
    test_en = 1'b1;
    wr(5'h1A, 8'h80, s);
    test_en = 1'b0;
    wr(5'h1A, 8'h00, s);
    chk("R8 mute kept set", {s[5], mute_active}, 2'b01);
    test_en = 1'b1;
    wr(5'h1A, 8'h00, s);
    chk("R6 unmute", mute_active, 0);
  endtask

  task automatic t_other_addr();
    logic [5:0] s;
    logic [8:0] r;
    test_en = 1'b1;
    rd(5'h17, r); chk("R9 read 17", r, 9'h000);
    rd(5'h1B, r); chk("R9 read 1B", r, 9'h000);
    wr(5'h1B, 8'h80, s); chk("R9 write 1B", {s[5], mute_active}, 2'b00);
    wr(5'h18, 8'h80, s); chk("R9 write 18", {s[5], mute_active}, 2'b00);
    wr(5'h02, 8'h80, s); chk("R9 write 02", {s[5], mute_active}, 2'b00);
  endtask

  initial begin
    #1 t_reset();
    #20 rst_n = 1'b1;
    t_reads();
    t_passthrough();
    t_phase_and_mute_same_write();
    t_test_off();
    t_other_addr();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule